// File: doc/BRIEF.md
# Perspective-Correct Barycentric Attribute Interpolator

This unit resolves one pixel at a time against a stored triangle. A triangle is loaded through a setup port. Each of its three vertices carries integer window coordinates, a homogeneous w value and a four-component attribute. Both w and the attribute components are unsigned Q8.8. The unit then accepts pixel queries on a stream port. For each query it tests whether the pixel centre lies inside the triangle, using signed sub-triangle areas. For a covered pixel it returns the attribute blended in a perspective-correct way: each vertex contributes its area weight divided by its own w, and the blend is renormalised by the interpolated 1/w.

All three ports use valid/ready. A transfer happens on a rising clock edge where both valid and ready are high.
- Only one query is in flight at a time. The pixel port drops ready from acceptance until the result has been taken.
- The result stays on the output unchanged for as long as the consumer holds out_ready low.
- A triangle can only be loaded while no pixel is in flight. If a triangle and a pixel are offered in the same cycle, the triangle wins.

The caller must supply non-zero w values.

Top module: `bary_persp_interp`

## Requirements
- R1: tri_ready is high whenever no pixel is in flight. A triangle is captured on a tri_valid and tri_ready edge. While tri_valid is high, px_ready is low, so a triangle load takes priority over a pixel in the same cycle. After reset tri_ready and px_ready are high and out_valid is low.
- R2: Vertex i (i = 0, 1, 2, called A, B, C) takes x from tri_x[i*XW +: XW] and y from tri_y[i*XW +: XW]. The pixel is tested at its centre (x+0.5, y+0.5). The pixel is covered when the doubled total area of A-B-C is non-zero and each of the three sub-areas (P-B-C, A-P-C, A-B-P) is zero or has the same sign as the total. Either winding order gives the same coverage.
- R3: A triangle with three collinear vertices covers no pixel.
- R4: For a covered pixel, component k of the result is out_attr[k*16 +: 16]. It is the Q8.8 value Σ a_i·C_ik/w_i ÷ Σ a_i/w_i, rounded down. Here a_i is the magnitude of the sub-area opposite vertex i (area B-P-C for A). C_ik comes from tri_attr[(i*4+k)*16 +: 16] and w_i from tri_w[i*16 +: 16].
- R5: When all three w are equal, a covered pixel's result equals the plain screen-space blend Σ a_i·C_ik ÷ |total area|, rounded down.
- R6: An uncovered pixel is returned with out_covered = 0 and all of out_attr equal to zero.
- R7: out_valid rises exactly ATTR_W+1 clock edges after the edge that accepted the query.
- R8: px_ready and tri_ready stay low from a query's acceptance until its result is taken. Results therefore come out in query order, and out_valid drops on the edge that completes the output handshake.
- R9: While out_valid is high and out_ready is low, out_valid, out_covered and out_attr hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tri_valid | input | 1 | Triangle offered |
| tri_ready | output | 1 | Triangle can be captured |
| tri_x | input | 3*XW | Vertex x coordinates, vertex i at bits i*XW |
| tri_y | input | 3*XW | Vertex y coordinates |
| tri_w | input | 3*ATTR_W | Vertex w, unsigned Q8.8, non-zero |
| tri_attr | input | 3*NCOMP*ATTR_W | Vertex attributes, Q8.8 |
| px_valid | input | 1 | Pixel query offered |
| px_ready | output | 1 | Pixel query can be accepted |
| px_x | input | XW | Pixel column |
| px_y | input | XW | Pixel row |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_covered | output | 1 | Pixel centre inside the triangle |
| out_attr | output | NCOMP*ATTR_W | Interpolated attribute, zero when not covered |

## Verification
Several properties are checked on every cycle:
- the fixed result latency, measured with a counter;
- the single-query-in-flight ready behaviour and the priority of a triangle load over a pixel;
- holding of the result under back-pressure;
- the zero attribute returned with an uncovered flag.

Whether coverage and the perspective-weighted blend are numerically right can only be shown by the bench. It sweeps every pixel of a 12x12 window against triangles of both windings, a degenerate triangle, an equal-w triangle and one with extreme w and attribute values, and compares each result with an exact rational reference.

// File: rtl/bpi_pkg.sv
package bpi_pkg;
  localparam int N_VERT = 3;
  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_DIV, ST_DONE} bpi_state_e;
endpackage

// File: rtl/bary_edge.sv
// Signed-area coverage test on doubled coordinates (pixel centre at 2p+1).
module bary_edge #(
  parameter int XW = 8,
  localparam int AW = 2*XW+5
) (
  input  logic [3*XW-1:0] tri_x,
  input  logic [3*XW-1:0] tri_y,
  input  logic [XW-1:0]   pix_x,
  input  logic [XW-1:0]   pix_y,
  output logic            covered,
  output logic [3*AW-1:0] mag
);
  typedef logic signed [XW+1:0] crd_t;

  function automatic logic signed [AW-1:0] area2(input crd_t ax, input crd_t ay,
                                                input crd_t bx, input crd_t by,
                                                input crd_t cx, input crd_t cy);
    logic signed [XW+2:0] d0, d1, d2, d3;
    logic signed [AW-1:0] e0, e1, e2, e3;
    d0 = {bx[XW+1], bx} - {ax[XW+1], ax};
    d1 = {cy[XW+1], cy} - {ay[XW+1], ay};
    d2 = {by[XW+1], by} - {ay[XW+1], ay};
    d3 = {cx[XW+1], cx} - {ax[XW+1], ax};
    e0 = {{(AW-XW-3){d0[XW+2]}}, d0};
    e1 = {{(AW-XW-3){d1[XW+2]}}, d1};
    e2 = {{(AW-XW-3){d2[XW+2]}}, d2};
    e3 = {{(AW-XW-3){d3[XW+2]}}, d3};
    return e0*e1 - e2*e3;
  endfunction

  crd_t vx [3];
  crd_t vy [3];
  crd_t qx, qy;
  logic signed [AW-1:0] tot;
  logic signed [AW-1:0] sub [3];
  logic [2:0] side_ok;

  always_comb begin
    for (int i = 0; i < 3; i++) begin
      vx[i] = {1'b0, tri_x[i*XW +: XW], 1'b0};
      vy[i] = {1'b0, tri_y[i*XW +: XW], 1'b0};
    end
    qx = {1'b0, pix_x, 1'b1};
    qy = {1'b0, pix_y, 1'b1};
    tot    = area2(vx[0], vy[0], vx[1], vy[1], vx[2], vy[2]);
    sub[0] = area2(qx, qy, vx[1], vy[1], vx[2], vy[2]);
    sub[1] = area2(vx[0], vy[0], qx, qy, vx[2], vy[2]);
    sub[2] = area2(vx[0], vy[0], vx[1], vy[1], qx, qy);
    for (int i = 0; i < 3; i++) begin
      side_ok[i] = tot[AW-1] ? (sub[i][AW-1] || sub[i] == '0) : !sub[i][AW-1];
      mag[i*AW +: AW] = tot[AW-1] ? AW'(-sub[i]) : AW'(sub[i]);
    end
    covered = (tot != '0) && (&side_ok);
  end
endmodule

// File: rtl/persp_div.sv
// Restoring divider, one quotient bit per step, MSB first.
module persp_div #(
  parameter int NUM_W = 71,
  parameter int DEN_W = 55,
  parameter int QW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             step,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [QW-1:0]    quo
);
  logic [NUM_W-1:0] rem_q, dsh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      dsh_q <= '0;
      quo   <= '0;
    end else if (load) begin
      rem_q <= num;
      dsh_q <= NUM_W'(den) << (QW-1);
      quo   <= '0;
    end else if (step) begin
      if (rem_q >= dsh_q) begin
        rem_q <= rem_q - dsh_q;
        quo   <= {quo[QW-2:0], 1'b1};
      end else begin
        quo   <= {quo[QW-2:0], 1'b0};
      end
      dsh_q <= dsh_q >> 1;
    end
  end
endmodule

// File: rtl/bary_persp_interp.sv
module bary_persp_interp
  import bpi_pkg::*;
#(
  parameter int XW     = 8,
  parameter int ATTR_W = 16,
  parameter int NCOMP  = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tri_valid,
  output logic                         tri_ready,
  input  logic [3*XW-1:0]              tri_x,
  input  logic [3*XW-1:0]              tri_y,
  input  logic [3*ATTR_W-1:0]          tri_w,
  input  logic [3*NCOMP*ATTR_W-1:0]    tri_attr,
  input  logic                         px_valid,
  output logic                         px_ready,
  input  logic [XW-1:0]                px_x,
  input  logic [XW-1:0]                px_y,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic                         out_covered,
  output logic [NCOMP*ATTR_W-1:0]      out_attr
);
  localparam int AREA_W = 2*XW+5;
  localparam int PW     = 2*ATTR_W;
  localparam int DEN_W  = AREA_W+PW+2;
  localparam int NUM_W  = DEN_W+ATTR_W;
  localparam int CNT_W  = $clog2(ATTR_W);

  logic [3*XW-1:0]           tx_q, ty_q;
  logic [3*ATTR_W-1:0]       tw_q;
  logic [3*NCOMP*ATTR_W-1:0] ta_q;
  logic [XW-1:0]             qx_q, qy_q;
  bpi_state_e                st_q;
  logic [CNT_W-1:0]          cnt_q;
  logic                      cov_q;

  logic                      cov_c;
  logic [3*AREA_W-1:0]       mag_c;
  logic [PW-1:0]             pw [N_VERT];
  logic [DEN_W-1:0]          term [N_VERT];
  logic [DEN_W-1:0]          den_c;
  logic [NUM_W-1:0]          num_c [NCOMP];
  logic                      div_load, div_step;

  bary_edge #(.XW(XW)) u_edge (
    .tri_x(tx_q), .tri_y(ty_q), .pix_x(qx_q), .pix_y(qy_q),
    .covered(cov_c), .mag(mag_c)
  );

  // Scaling both sums by w0*w1*w2 turns the 1/w weights into products.
  always_comb begin
    den_c = '0;
    for (int i = 0; i < N_VERT; i++) begin
      pw[i]   = PW'(tw_q[((i+1)%N_VERT)*ATTR_W +: ATTR_W]) *
                PW'(tw_q[((i+2)%N_VERT)*ATTR_W +: ATTR_W]);
      term[i] = DEN_W'(mag_c[i*AREA_W +: AREA_W]) * DEN_W'(pw[i]);
      den_c   = den_c + term[i];
    end
    for (int k = 0; k < NCOMP; k++) begin
      num_c[k] = '0;
      for (int i = 0; i < N_VERT; i++)
        num_c[k] = num_c[k] + NUM_W'(term[i]) *
                   NUM_W'(ta_q[(i*NCOMP+k)*ATTR_W +: ATTR_W]);
    end
    if (!cov_c) begin
      den_c = DEN_W'(1);
      for (int k = 0; k < NCOMP; k++) num_c[k] = '0;
    end
  end

  assign tri_ready   = (st_q == ST_IDLE);
  assign px_ready    = (st_q == ST_IDLE) && !tri_valid;
  assign out_valid   = (st_q == ST_DONE);
  assign out_covered = cov_q;
  assign div_load    = (st_q == ST_SETUP);
  assign div_step    = (st_q == ST_DIV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      tx_q  <= '0;
      ty_q  <= '0;
      tw_q  <= '0;
      ta_q  <= '0;
      qx_q  <= '0;
      qy_q  <= '0;
      cnt_q <= '0;
      cov_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (tri_valid) begin
            tx_q <= tri_x;
            ty_q <= tri_y;
            tw_q <= tri_w;
            ta_q <= tri_attr;
          end else if (px_valid) begin
            qx_q <= px_x;
            qy_q <= px_y;
            st_q <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          cov_q <= cov_c;
          cnt_q <= '0;
          st_q  <= ST_DIV;
        end
        ST_DIV: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ATTR_W-1)) st_q <= ST_DONE;
        end
        ST_DONE: if (out_ready) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar k = 0; k < NCOMP; k++) begin : g_div
    persp_div #(.NUM_W(NUM_W), .DEN_W(DEN_W), .QW(ATTR_W)) u_div (
      .clk(clk), .rst_n(rst_n), .load(div_load), .step(div_step),
      .num(num_c[k]), .den(den_c), .quo(out_attr[k*ATTR_W +: ATTR_W])
    );
  end
endmodule

// File: rtl/bpi_checker.sv
module bpi_checker #(
  parameter int XW     = 8,
  parameter int ATTR_W = 16,
  parameter int NCOMP  = 4
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tri_valid,
  input logic                      tri_ready,
  input logic                      px_valid,
  input logic                      px_ready,
  input logic                      out_valid,
  input logic                      out_ready,
  input logic                      out_covered,
  input logic [NCOMP*ATTR_W-1:0]   out_attr
);
  localparam int LATENCY = ATTR_W+1;
  logic [7:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else if (px_valid && px_ready) lat_q <= '0;
    else if (!out_valid && lat_q != 8'hFF) lat_q <= lat_q + 8'd1;
  end

  AST_TRI_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    tri_valid |-> !px_ready); // R1
  AST_ZERO_WHEN_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_covered) |-> (out_attr == '0)); // R6
  AST_FIXED_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_q == 8'(LATENCY))); // R7
  AST_SINGLE_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (px_valid && px_ready) |=> (!px_ready && !tri_ready)); // R8
  AST_BUSY_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!px_ready && !tri_ready)); // R8
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_attr) && $stable(out_covered))); // R9
endmodule

bind bary_persp_interp bpi_checker #(.XW(XW), .ATTR_W(ATTR_W), .NCOMP(NCOMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tri_valid(tri_valid), .tri_ready(tri_ready),
  .px_valid(px_valid), .px_ready(px_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_covered(out_covered), .out_attr(out_attr)
);

// File: tb/sim_bary_persp_interp.sv
`timescale 1ns/1ps
module sim_bary_persp_interp;
  localparam int XW = 8;
  localparam int AW = 16;
  localparam int NC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tri_valid = 1'b0, px_valid = 1'b0, out_ready = 1'b0;
  logic tri_ready, px_ready, out_valid, out_covered;
  logic [3*XW-1:0] tri_x = '0, tri_y = '0;
  logic [3*AW-1:0] tri_w = '0;
  logic [3*NC*AW-1:0] tri_attr = '0;
  logic [XW-1:0] px_x = '0, px_y = '0;
  logic [NC*AW-1:0] out_attr;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  int vx [3], vy [3];
  logic [15:0] vw [3];
  logic [15:0] va [3][NC];
  bit exp_cov;
  logic [15:0] exp_a [NC];
  longint tot_area;

  always #4 clk = ~clk;

  bary_persp_interp #(.XW(XW), .ATTR_W(AW), .NCOMP(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .tri_valid(tri_valid), .tri_ready(tri_ready),
    .tri_x(tri_x), .tri_y(tri_y), .tri_w(tri_w), .tri_attr(tri_attr),
    .px_valid(px_valid), .px_ready(px_ready), .px_x(px_x), .px_y(px_y),
    .out_valid(out_valid), .out_ready(out_ready), .out_covered(out_covered),
    .out_attr(out_attr)
  );

  task automatic chk(bit ok, string tag, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic void compute_ref(int px, int py, bit lin);
    longint ax, ay, bx, by, cx, cy, qx, qy, ea, eb, ec;
    longint m [3];
    logic [127:0] p [3];
    logic [127:0] n, d;
    ax = 2*vx[0]; ay = 2*vy[0]; bx = 2*vx[1]; by = 2*vy[1];
    cx = 2*vx[2]; cy = 2*vy[2]; qx = 2*px+1; qy = 2*py+1;
    tot_area = (bx-ax)*(cy-ay) - (by-ay)*(cx-ax);
    ea = (bx-qx)*(cy-qy) - (by-qy)*(cx-qx);
    eb = (qx-ax)*(cy-ay) - (qy-ay)*(cx-ax);
    ec = tot_area - ea - eb;
    exp_cov = (tot_area > 0 && ea >= 0 && eb >= 0 && ec >= 0) ||
              (tot_area < 0 && ea <= 0 && eb <= 0 && ec <= 0);
    m[0] = ea < 0 ? -ea : ea;
    m[1] = eb < 0 ? -eb : eb;
    m[2] = ec < 0 ? -ec : ec;
    p[0] = 128'(vw[1]) * 128'(vw[2]);
    p[1] = 128'(vw[0]) * 128'(vw[2]);
    p[2] = 128'(vw[0]) * 128'(vw[1]);
    for (int k = 0; k < NC; k++) begin
      if (!exp_cov) exp_a[k] = '0;
      else if (lin) begin
        n = '0;
        for (int i = 0; i < 3; i++) n += 128'(m[i]) * 128'(va[i][k]);
        d = 128'(tot_area < 0 ? -tot_area : tot_area);
        exp_a[k] = 16'(n / d);
      end else begin
        n = '0; d = '0;
        for (int i = 0; i < 3; i++) begin
          n += 128'(m[i]) * 128'(va[i][k]) * p[i];
          d += 128'(m[i]) * p[i];
        end
        exp_a[k] = 16'(n / d);
      end
    end
  endfunction

  task automatic load_tri();
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      tri_x[i*XW +: XW] = XW'(vx[i]);
      tri_y[i*XW +: XW] = XW'(vy[i]);
      tri_w[i*AW +: AW] = vw[i];
      for (int k = 0; k < NC; k++) tri_attr[(i*NC+k)*AW +: AW] = va[i][k];
    end
    tri_valid = 1'b1;
    px_valid = 1'b1;
    #1;
    chk(tri_ready == 1'b1, "R1", "tri_ready idle", longint'(tri_ready), 1);
    chk(px_ready == 1'b0, "R1", "px_ready under tri_valid", longint'(px_ready), 0);
    @(posedge clk);
    @(negedge clk);
    tri_valid = 1'b0;
    px_valid = 1'b0;
  endtask

  task automatic run_pix(int px, int py, bit lin, int hold);
    int cyc;
    logic [NC*AW-1:0] snap;
    string tag;
    compute_ref(px, py, lin);
    @(negedge clk);
    px_x = XW'(px); px_y = XW'(py); px_valid = 1'b1; out_ready = 1'b0;
    while (!px_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    px_valid = 1'b0;
    cyc = 0;
    while (!out_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc == AW+1, "R7", "latency", cyc, AW+1);
    chk(px_ready == 1'b0 && tri_ready == 1'b0, "R8", "ready while busy",
        longint'({px_ready, tri_ready}), 0);
    tag = (tot_area == 0) ? "R3" : "R2";
    chk(out_covered == exp_cov, tag, $sformatf("cover (%0d,%0d)", px, py),
        longint'(out_covered), longint'(exp_cov));
    tag = !exp_cov ? "R6" : (lin ? "R5" : "R4");
    for (int k = 0; k < NC; k++)
      chk(out_attr[k*AW +: AW] == exp_a[k], tag,
          $sformatf("attr%0d (%0d,%0d)", k, px, py),
          longint'(out_attr[k*AW +: AW]), longint'(exp_a[k]));
    snap = out_attr;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(out_valid && out_attr == snap && out_covered == exp_cov, "R9",
          "hold under back-pressure", longint'(out_attr[15:0]), longint'(snap[15:0]));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    chk(out_valid == 1'b0 && px_ready == 1'b1, "R8", "released after handshake",
        longint'({out_valid, px_ready}), 1);
  endtask

  task automatic sweep(bit lin);
    load_tri();
    for (int y = 0; y < 12; y++)
      for (int x = 0; x < 12; x++)
        run_pix(x, y, lin, 0);
  endtask

  task automatic set_vtx(int i, int x, int y, logic [15:0] w,
                         logic [15:0] a0, logic [15:0] a1, logic [15:0] a2, logic [15:0] a3);
    vx[i] = x; vy[i] = y; vw[i] = w;
    va[i][0] = a0; va[i][1] = a1; va[i][2] = a2; va[i][3] = a3;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && tri_ready == 1'b1 && px_ready == 1'b1, "R1",
        "reset state", longint'({out_valid, tri_ready, px_ready}), 3);

    // counter-clockwise, distinct w
    set_vtx(0, 1, 1, 16'h0100, 16'h0000, 16'hFF00, 16'h1234, 16'h0100);
    set_vtx(1, 10, 2, 16'h0400, 16'hFF00, 16'h0000, 16'h8000, 16'h0200);
    set_vtx(2, 3, 10, 16'h0080, 16'h0800, 16'h0800, 16'h0001, 16'hFFFF);
    sweep(1'b0);
    run_pix(4, 4, 1'b0, 5);
    run_pix(11, 11, 1'b0, 3);

    // same triangle, clockwise order
    set_vtx(0, 1, 1, 16'h0100, 16'h0000, 16'hFF00, 16'h1234, 16'h0100);
    set_vtx(1, 3, 10, 16'h0080, 16'h0800, 16'h0800, 16'h0001, 16'hFFFF);
    set_vtx(2, 10, 2, 16'h0400, 16'hFF00, 16'h0000, 16'h8000, 16'h0200);
    sweep(1'b0);

    // collinear vertices
    set_vtx(0, 0, 0, 16'h0100, 16'h1111, 16'h2222, 16'h3333, 16'h4444);
    set_vtx(1, 5, 5, 16'h0200, 16'h5555, 16'h6666, 16'h7777, 16'h8888);
    set_vtx(2, 10, 10, 16'h0300, 16'h9999, 16'hAAAA, 16'hBBBB, 16'hCCCC);
    sweep(1'b0);

    // equal w: linear blend
    set_vtx(0, 0, 11, 16'h0200, 16'h0000, 16'h1000, 16'hFFFF, 16'h0300);
    set_vtx(1, 11, 11, 16'h0200, 16'hFFFF, 16'h2000, 16'h0000, 16'h0700);
    set_vtx(2, 6, 0, 16'h0200, 16'h8000, 16'h3000, 16'h7FFF, 16'h0B00);
    sweep(1'b1);

    // extreme w and attributes
    set_vtx(0, 0, 0, 16'hFFFF, 16'hFFFF, 16'h0000, 16'h0001, 16'hFFFF);
    set_vtx(1, 11, 0, 16'h0001, 16'h0000, 16'hFFFF, 16'hFFFE, 16'hFFFF);
    set_vtx(2, 0, 11, 16'h8000, 16'h7FFF, 16'h0001, 16'hFFFF, 16'hFFFF);
    sweep(1'b0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule